// File: doc/BRIEF.md
# Shadow-Mapped DMA Submission Registers

This block is the register front end of a fast DMA request path. It holds five 32-bit transfer parameters: options, source address, destination address, count and index. A processor writes them over a simple write-only 32-bit slave port that can take one write every clock cycle. Each parameter can be reached at two addresses. A store to the plain address only updates the parameter. A store to the aliased address updates the same parameter and also issues a transfer request.

That request carries a copy of all five parameters, and the copy includes the value just written. Software therefore loads four parameters with ordinary stores and issues the transfer with its last store, which goes through the alias. The request leaves through a valid/ready port. A one-entry buffer sits in front of that port. When the buffer is still occupied, the write port stalls further submitting stores.

Top module: `qsub_regfront`

## Requirements
- R1: After reset every parameter register reads as zero in a later request, and `req_valid` is low.
- R2: A write to byte offset 0x00, 0x04, 0x08, 0x0C or 0x10 stores into options, source, destination, count or index respectively, and issues no request.
- R3: A write to byte offset 0x20 plus a parameter's offset stores into that parameter and raises `req_valid` on the next cycle. The request carries all five parameters, and the written field holds the new value.
- R4: The count parameter is presented as `req_lines` (bits 31:16) and `req_elems` (bits 15:0).
- R5: Every accepted write replaces all 32 bits of its register, whatever `wr_be` holds, including `wr_be` = 0.
- R6: Writes to addresses that lie in neither window (offsets 0x14–0x1C, 0x34 and above) change nothing and issue no request.
- R7: `rd_data` is zero at all times.
- R8: When no stall applies, `wr_ready` is high and a new write is accepted on every consecutive cycle.
- R9: A write through the alias while a request is pending and `req_ready` is low sees `wr_ready` low and is not taken. Plain-address writes are still accepted at that time.
- R10: The request copy is taken in the cycle of the submitting write, so later writes to the parameters leave a pending request unchanged.
- R11: `req_valid` stays high with a stable payload until `req_ready` is seen. A submitting write in the cycle of that hand-off refills the buffer at once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_valid | input | 1 | Write strobe |
| wr_ready | output | 1 | Write can be accepted this cycle |
| wr_addr | input | 8 | Byte address within the block |
| wr_data | input | 32 | Write data |
| wr_be | input | 4 | Byte enables (have no effect) |
| rd_en | input | 1 | Read strobe (reads return zero) |
| rd_data | output | 32 | Read data, always zero |
| req_valid | output | 1 | Transfer request pending |
| req_ready | input | 1 | Consumer takes the request |
| req_opt | output | 32 | Options snapshot |
| req_src | output | 32 | Source snapshot |
| req_dst | output | 32 | Destination snapshot |
| req_lines | output | 16 | Line/frame count snapshot |
| req_elems | output | 16 | Element count snapshot |
| req_idx | output | 32 | Index snapshot |

## Verification
On every cycle, the assertions check four things. A new request appears only after an accepted write through the alias. A pending request holds still until it is taken. The buffer is never loaded while it is full and not draining. The register-bank write index stays inside the bank. The bench's scenarios are needed for everything tied to data values: that the copy merges the new value with the older ones, that the count field is split, that byte enables and out-of-window addresses have no effect, and that writes after a submission stay out of the pending request. Back-to-back throughput and the stall, which blocks only alias writes, are also shown by the bench.

// File: rtl/qsub_pkg.sv
package qsub_pkg;
  localparam int unsigned NUM_REGS = 5;
  localparam int unsigned WORD_W   = 32;

  localparam int unsigned IDX_OPT = 0;
  localparam int unsigned IDX_SRC = 1;
  localparam int unsigned IDX_DST = 2;
  localparam int unsigned IDX_CNT = 3;
  localparam int unsigned IDX_IDX = 4;

  typedef logic [WORD_W-1:0] word_t;

  typedef struct packed {
    word_t opt;
    word_t src;
    word_t dst;
    word_t cnt;
    word_t idx;
  } xfer_req_t;
endpackage

// File: rtl/qsub_decode.sv
module qsub_decode #(
  parameter int unsigned ADDR_W = 8,
  parameter int unsigned NUM    = 5,
  localparam int unsigned IDX_W  = $clog2(NUM),
  localparam int unsigned WIN_LSB = IDX_W + 2
) (
  input  logic [ADDR_W-1:0] addr_i,
  output logic              hit_o,
  output logic              alias_o,
  output logic [IDX_W-1:0]  idx_o
);
  logic [ADDR_W-1:0] upper;
  logic [IDX_W-1:0]  word;
  logic              unused_lsb;

  always_comb begin
    word    = addr_i[WIN_LSB-1:2];
    upper   = addr_i >> (WIN_LSB + 1);
    hit_o   = (upper == '0) && (int'(word) < int'(NUM));
    alias_o = addr_i[WIN_LSB];
    idx_o   = word;
  end

  assign unused_lsb = ^addr_i[1:0];
endmodule

// File: rtl/qsub_regbank.sv
module qsub_regbank #(
  parameter int unsigned NUM = 5,
  parameter int unsigned DW  = 32,
  localparam int unsigned IDX_W = $clog2(NUM)
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   wr_en_i,
  input  logic [IDX_W-1:0]       wr_idx_i,
  input  logic [DW-1:0]          wr_data_i,
  output logic [NUM-1:0][DW-1:0] snap_o
);
  for (genvar g = 0; g < NUM; g++) begin : g_reg
    logic          we;
    logic [DW-1:0] q;
    logic [DW-1:0] d;

    always_comb begin
      we = wr_en_i && (int'(wr_idx_i) == g);
      d  = we ? wr_data_i : q;
      snap_o[g] = d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        q <= '0;
      end else if (we) begin
        q <= d;
      end
    end
  end

  a_r2_idx_in_range: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en_i |-> (int'(wr_idx_i) < int'(NUM)));
endmodule

// File: rtl/qsub_reqbuf.sv
module qsub_reqbuf #(
  parameter int unsigned PW = 160
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load_i,
  input  logic [PW-1:0] data_i,
  output logic          full_o,
  output logic          out_valid_o,
  input  logic          out_ready_i,
  output logic [PW-1:0] out_data_o
);
  logic          full_q, full_d;
  logic [PW-1:0] data_q;

  always_comb begin
    full_d = full_q;
    if (load_i)                    full_d = 1'b1;
    else if (full_q && out_ready_i) full_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) full_q <= 1'b0;
    else        full_q <= full_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      data_q <= '0;
    else if (load_i) data_q <= data_i;
  end

  assign full_o      = full_q;
  assign out_valid_o = full_q;
  assign out_data_o  = data_q;

  a_r9_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
    load_i |-> (!full_q || out_ready_i));

  a_r11_hold_until_taken: assert property (@(posedge clk) disable iff (!rst_n)
    (full_q && !out_ready_i) |=> (full_q && $stable(data_q)));
endmodule

// File: rtl/qsub_regfront.sv
module qsub_regfront #(
  parameter int unsigned ADDR_W = 8
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        wr_valid,
  output logic        wr_ready,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [31:0] wr_data,
  input  logic [3:0]  wr_be,
  input  logic        rd_en,
  output logic [31:0] rd_data,
  output logic        req_valid,
  input  logic        req_ready,
  output logic [31:0] req_opt,
  output logic [31:0] req_src,
  output logic [31:0] req_dst,
  output logic [15:0] req_lines,
  output logic [15:0] req_elems,
  output logic [31:0] req_idx
);
  import qsub_pkg::*;

  localparam int unsigned IDX_W = $clog2(NUM_REGS);
  localparam int unsigned PW    = $bits(xfer_req_t);

  logic                          dec_hit, dec_alias;
  logic [IDX_W-1:0]              dec_idx;
  logic                          buf_full;
  logic                          accept, submit;
  logic [NUM_REGS-1:0][WORD_W-1:0] snap;
  xfer_req_t                     snap_req, out_req;
  logic [PW-1:0]                 out_bits;
  logic                          unused_ok;

  qsub_decode #(.ADDR_W(ADDR_W), .NUM(NUM_REGS)) u_dec (
    .addr_i (wr_addr),
    .hit_o  (dec_hit),
    .alias_o(dec_alias),
    .idx_o  (dec_idx)
  );

  always_comb begin
    wr_ready = !(dec_hit && dec_alias && buf_full && !req_ready);
    accept   = wr_valid && wr_ready && dec_hit;
    submit   = accept && dec_alias;
  end

  qsub_regbank #(.NUM(NUM_REGS), .DW(WORD_W)) u_bank (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en_i  (accept),
    .wr_idx_i (dec_idx),
    .wr_data_i(wr_data),
    .snap_o   (snap)
  );

  always_comb begin
    snap_req.opt = snap[IDX_OPT];
    snap_req.src = snap[IDX_SRC];
    snap_req.dst = snap[IDX_DST];
    snap_req.cnt = snap[IDX_CNT];
    snap_req.idx = snap[IDX_IDX];
  end

  qsub_reqbuf #(.PW(PW)) u_buf (
    .clk        (clk),
    .rst_n      (rst_n),
    .load_i     (submit),
    .data_i     (snap_req),
    .full_o     (buf_full),
    .out_valid_o(req_valid),
    .out_ready_i(req_ready),
    .out_data_o (out_bits)
  );

  always_comb begin
    out_req   = xfer_req_t'(out_bits);
    req_opt   = out_req.opt;
    req_src   = out_req.src;
    req_dst   = out_req.dst;
    req_lines = out_req.cnt[31:16];
    req_elems = out_req.cnt[15:0];
    req_idx   = out_req.idx;
    rd_data   = '0;
  end

  assign unused_ok = ^{wr_be, rd_en};

  a_r3_submit_only_alias: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(req_valid) |-> $past(wr_valid && wr_ready && dec_hit && dec_alias));
endmodule

// File: tb/qsub_regfront_tb.sv
module qsub_regfront_tb;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        wr_valid, wr_ready, rd_en, req_valid, req_ready;
  logic [7:0]  wr_addr;
  logic [31:0] wr_data, rd_data, req_opt, req_src, req_dst, req_idx;
  logic [3:0]  wr_be;
  logic [15:0] req_lines, req_elems;

  int n_chk = 0;
  int n_bad = 0;
  logic [31:0] mdl [5];
  logic [31:0] pend [5];

  always #4 clk = ~clk;

  qsub_regfront u_dut (
    .clk(clk), .rst_n(rst_n), .wr_valid(wr_valid), .wr_ready(wr_ready),
    .wr_addr(wr_addr), .wr_data(wr_data), .wr_be(wr_be), .rd_en(rd_en),
    .rd_data(rd_data), .req_valid(req_valid), .req_ready(req_ready),
    .req_opt(req_opt), .req_src(req_src), .req_dst(req_dst),
    .req_lines(req_lines), .req_elems(req_elems), .req_idx(req_idx)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic summary();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  // single write; waits while stalled; updates model for in-window addresses
  task automatic wr(input logic [7:0] a, input logic [31:0] d, input logic [3:0] be);
    @(negedge clk);
    wr_valid = 1'b1; wr_addr = a; wr_data = d; wr_be = be;
    #1;
    while (!wr_ready) begin @(negedge clk); #1; end
    @(posedge clk);
    if ((a >> 6) == 0 && a[4:2] < 5) mdl[a[4:2]] = d;
    if ((a >> 6) == 0 && a[4:2] < 5 && a[5]) for (int i = 0; i < 5; i++) pend[i] = mdl[i];
    #1 wr_valid = 1'b0;
  endtask

  task automatic chk_req(input string tag);
    @(negedge clk);
    check({tag, " valid"}, {31'd0, req_valid}, 32'd1);
    check({tag, " opt"}, req_opt, pend[0]);
    check({tag, " src"}, req_src, pend[1]);
    check({tag, " dst"}, req_dst, pend[2]);
    check({tag, " cnt"}, {req_lines, req_elems}, pend[3]);
    check({tag, " idx"}, req_idx, pend[4]);
  endtask

  task automatic take();
    @(negedge clk); req_ready = 1'b1;
    @(posedge clk); #1 req_ready = 1'b0;
  endtask

  task automatic t_reset();
    @(negedge clk);
    check("R1 req_valid after reset", {31'd0, req_valid}, 32'd0);
    check("R7 rd_data", rd_data, 32'd0);
    wr(8'h24, 32'h0000_1111, 4'hF);           // submit via alias src
    chk_req("R1 reset values");
    take();
  endtask

  task automatic t_phys();
    wr(8'h00, 32'hA000_0001, 4'hF);
    wr(8'h08, 32'hD000_0008, 4'hF);
    wr(8'h0C, 32'h0003_0040, 4'hF);
    wr(8'h10, 32'h0000_0004, 4'hF);
    @(negedge clk);
    check("R2 no request from plain writes", {31'd0, req_valid}, 32'd0);
    wr(8'h24, 32'h5000_0004, 4'hF);
    chk_req("R3 alias submit");
    check("R4 lines", {16'd0, req_lines}, 32'h3);
    check("R4 elems", {16'd0, req_elems}, 32'h40);
    take();
    @(negedge clk);
    check("R11 valid drops after take", {31'd0, req_valid}, 32'd0);
  endtask

  task automatic t_be_window();
    wr(8'h04, 32'hCAFE_BEEF, 4'h0);           // zero byte enables still write
    wr(8'h14, 32'hDEAD_0014, 4'hF);           // holes: ignored
    wr(8'h34, 32'hDEAD_0034, 4'hF);
    wr(8'h44, 32'hDEAD_0044, 4'hF);
    @(negedge clk);
    check("R6 no request from out-of-window", {31'd0, req_valid}, 32'd0);
    wr(8'h30, 32'h0000_0099, 4'h1);
    chk_req("R5 R6 full word and holes");
    check("R5 src full word", req_src, 32'hCAFE_BEEF);
    take();
  endtask

  task automatic t_b2b();
    @(negedge clk);
    wr_valid = 1'b1; rd_en = 1'b1;
    for (int i = 0; i < 4; i++) begin
      wr_addr = 8'(i * 4); wr_data = 32'h1000_0000 + 32'(i);
      #1 check("R8 ready back-to-back", {31'd0, wr_ready}, 32'd1);
      check("R7 rd_data on read", rd_data, 32'd0);
      @(posedge clk); mdl[i] = 32'h1000_0000 + 32'(i);
      @(negedge clk);
    end
    wr_valid = 1'b0; rd_en = 1'b0;
    wr(8'h30, 32'h0000_0777, 4'hF);
    chk_req("R8 back-to-back values");
    take();
  endtask

  task automatic t_stall();
    logic [31:0] first [5];
    wr(8'h20, 32'h0000_00A1, 4'hF);           // request A pending
    for (int i = 0; i < 5; i++) first[i] = pend[i];
    wr(8'h08, 32'h0000_0D0D, 4'hF);           // plain write accepted while full
    @(negedge clk);
    check("R10 pending dst unchanged", req_dst, first[2]);
    wr_valid = 1'b1; wr_addr = 8'h24; wr_data = 32'h0000_0B0B; wr_be = 4'hF;
    #1 check("R9 alias stalled", {31'd0, wr_ready}, 32'd0);
    @(negedge clk);
    check("R11 payload held opt", req_opt, first[0]);
    check("R10 payload held src", req_src, first[1]);
    req_ready = 1'b1;
    #1 check("R9 ready on drain", {31'd0, wr_ready}, 32'd1);
    @(posedge clk);
    mdl[1] = 32'h0000_0B0B;
    for (int i = 0; i < 5; i++) pend[i] = mdl[i];
    #1 req_ready = 1'b0; wr_valid = 1'b0;
    chk_req("R11 refill on hand-off");
    take();
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
  end

  initial begin
    for (int i = 0; i < 5; i++) begin mdl[i] = '0; pend[i] = '0; end
    rst_n = 1'b0; wr_valid = 1'b0; wr_addr = '0; wr_data = '0; wr_be = '0;
    rd_en = 1'b0; req_ready = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    t_reset();
    t_phys();
    t_be_window();
    t_b2b();
    t_stall();
    repeat (2) @(posedge clk);
    summary();
  end
endmodule